// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block carries a small 32-bit processor core into an exception handler. It watches four exception causes: a misaligned instruction address, an instruction fetch that hits no protection region, an instruction fetch that breaks the access rights of its region, and a debug breakpoint. When it accepts a cause, it forms the handler address by ORing a fixed offset for that cause into the vector base. It then builds the new status word. It also saves the return state, either on the system stack or in two debug shadow registers.

There are two entry paths. An ordinary exception pushes the current PC and then the current SR onto the stack, one word per cycle, with the stack pointer decremented before each write. The new PC, SR and SP appear in the cycle after the second write. A breakpoint writes nothing to the stack. It copies PC and SR into the debug shadow registers and presents the new state in the very next cycle. A separate return-from-debug request restores PC and SR from the shadow registers in one cycle.

The state machine has four states. `ST_IDLE` accepts requests. `ST_PUSH_PC` and `ST_PUSH_SR` make the two stack writes. `ST_COMMIT` presents the new state for one cycle. The transitions are as follows:
- IDLE→PUSH_PC on an ordinary exception.
- IDLE→COMMIT on a breakpoint or on a return-from-debug.
- PUSH_PC→PUSH_SR and PUSH_SR→COMMIT unconditionally.
- COMMIT→IDLE unconditionally.
- IDLE→IDLE when there is no request.

Top module: `exc_entry_seq`

## Requirements
- R1: When several causes are active in one IDLE cycle, exactly one is taken, in this order of precedence: breakpoint, then address misalignment, then protection miss, then protection violation.
- R2: The handler PC is the vector base ORed with 0x14 for misalignment, 0x50 for protection miss, 0x18 for protection violation and 0x1C for breakpoint.
- R3: On every entry, the new SR equals the old SR with bits [24:22] set to 3'b110, bit 21 (exception mask) set to 1 and bit 16 (global interrupt mask) set to 1. All other bits keep their old values, except as stated in R9.
- R4: The protection miss and protection violation causes are ignored while `prot_en_i` is low.
- R5: For an ordinary exception, the cycle after acceptance writes PC to address SP-4 with `busy_o` high. The following cycle writes SR to address SP-8.
- R6: For an ordinary exception, `pc_vld_o` is high in the third cycle after acceptance, with `new_sp_o` equal to SP-8 together with the R2 PC and the R3 SR.
- R7: `busy_o` is high in both write cycles and low when `pc_vld_o` rises. `pc_vld_o` lasts exactly one cycle.
- R8: A breakpoint is taken only when SR bit 27 (debug mode) is clear. Otherwise it is ignored, and the next cause in precedence order is considered.
- R9: On a breakpoint, `dbg_rar_o` takes the PC, `dbg_rsr_o` takes the SR, and no stack write occurs. In the next cycle `pc_vld_o` is high with `new_sp_o` equal to SP and the R3 SR that also has bit 26 and bit 27 set.
- R10: When `retd_i` is high in an IDLE cycle with no cause taken, the next cycle shows `pc_vld_o` with `new_pc_o` = `dbg_rar_o`, `new_sr_o` = `dbg_rsr_o` and `new_sp_o` = SP. A cause taken in the same cycle wins over `retd_i`.
- R11: Causes and `retd_i` are ignored whenever the state is not IDLE.
- R12: After reset, `busy_o`, `pc_vld_o` and `stk_we_o` are low, and both debug shadow registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bkpt_i | input | 1 | Debug breakpoint request |
| iaddr_err_i | input | 1 | Misaligned instruction address |
| imiss_i | input | 1 | Instruction fetch hit no protection region |
| iprot_i | input | 1 | Instruction fetch violated region rights |
| prot_en_i | input | 1 | Protection unit present and enabled |
| retd_i | input | 1 | Return from debug request |
| cur_pc_i | input | XLEN | Current PC (faulting or breakpoint instruction) |
| cur_sr_i | input | XLEN | Current status register |
| cur_sp_i | input | XLEN | Current system stack pointer |
| vec_base_i | input | XLEN | Exception vector base |
| busy_o | output | 1 | Stack save in progress |
| stk_we_o | output | 1 | Stack write strobe |
| stk_addr_o | output | XLEN | Stack write address |
| stk_data_o | output | XLEN | Stack write data |
| pc_vld_o | output | 1 | New PC/SR/SP valid (one cycle) |
| new_pc_o | output | XLEN | New PC |
| new_sr_o | output | XLEN | New SR |
| new_sp_o | output | XLEN | New SP |
| dbg_rar_o | output | XLEN | Debug return-address shadow register |
| dbg_rsr_o | output | XLEN | Debug status shadow register |

## Verification
A request is sampled at clock edge N. For an ordinary exception, the PC write is visible in the cycle after N, the SR write in the cycle after that, and the commit in the third cycle. A breakpoint, a return-from-debug, or the absence of any accepted request is resolved in the first cycle after N. The bench drives inputs and samples outputs on falling edges, and counts these cycles explicitly for each path. During the write cycles it raises spurious causes to show that they are ignored, and it removes them before the design returns to IDLE.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_SR,
        ST_COMMIT
    } seq_state_e;

    typedef enum logic [2:0] {
        CA_NONE,
        CA_BKPT,
        CA_IADDR,
        CA_IMISS,
        CA_IPROT
    } cause_e;

    localparam int SR_GM_BIT   = 16;
    localparam int SR_EM_BIT   = 21;
    localparam int SR_MODE_LSB = 22;
    localparam int SR_MODE_W   = 3;
    localparam int SR_D_BIT    = 26;
    localparam int SR_DM_BIT   = 27;
    localparam logic [SR_MODE_W-1:0] MODE_EXC = 3'b110;

endpackage

// File: rtl/exc_cause_arb.sv
module exc_cause_arb
    import exc_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int OFS_IADDR = 'h14,
    parameter int OFS_IMISS = 'h50,
    parameter int OFS_IPROT = 'h18,
    parameter int OFS_BKPT  = 'h1C
) (
    input  logic            bkpt,
    input  logic            iaddr_err,
    input  logic            imiss,
    input  logic            iprot,
    input  logic            prot_en,
    input  logic            dbg_mode,
    output cause_e          cause,
    output logic [XLEN-1:0] offset
);

    always_comb begin
        cause  = CA_NONE;
        offset = '0;
        if (bkpt && !dbg_mode) begin
            cause  = CA_BKPT;
            offset = XLEN'(OFS_BKPT);
        end else if (iaddr_err) begin
            cause  = CA_IADDR;
            offset = XLEN'(OFS_IADDR);
        end else if (prot_en && imiss) begin
            cause  = CA_IMISS;
            offset = XLEN'(OFS_IMISS);
        end else if (prot_en && iprot) begin
            cause  = CA_IPROT;
            offset = XLEN'(OFS_IPROT);
        end
    end

endmodule

// File: rtl/exc_sr_next.sv
module exc_sr_next
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] sr_in,
    input  logic            to_debug,
    output logic [XLEN-1:0] sr_out
);

    always_comb begin
        sr_out = sr_in;
        sr_out[SR_MODE_LSB +: SR_MODE_W] = MODE_EXC;
        sr_out[SR_EM_BIT] = 1'b1;
        sr_out[SR_GM_BIT] = 1'b1;
        if (to_debug) begin
            sr_out[SR_D_BIT]  = 1'b1;
            sr_out[SR_DM_BIT] = 1'b1;
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int WORD_BYTES = 4,
    parameter int OFS_IADDR  = 'h14,
    parameter int OFS_IMISS  = 'h50,
    parameter int OFS_IPROT  = 'h18,
    parameter int OFS_BKPT   = 'h1C
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bkpt_i,
    input  logic            iaddr_err_i,
    input  logic            imiss_i,
    input  logic            iprot_i,
    input  logic            prot_en_i,
    input  logic            retd_i,
    input  logic [XLEN-1:0] cur_pc_i,
    input  logic [XLEN-1:0] cur_sr_i,
    input  logic [XLEN-1:0] cur_sp_i,
    input  logic [XLEN-1:0] vec_base_i,
    output logic            busy_o,
    output logic            stk_we_o,
    output logic [XLEN-1:0] stk_addr_o,
    output logic [XLEN-1:0] stk_data_o,
    output logic            pc_vld_o,
    output logic [XLEN-1:0] new_pc_o,
    output logic [XLEN-1:0] new_sr_o,
    output logic [XLEN-1:0] new_sp_o,
    output logic [XLEN-1:0] dbg_rar_o,
    output logic [XLEN-1:0] dbg_rsr_o
);

    localparam logic [XLEN-1:0] WORD_STEP  = XLEN'(WORD_BYTES);
    localparam logic [XLEN-1:0] FRAME_SIZE = XLEN'(2 * WORD_BYTES);

    seq_state_e      state_q, state_d;
    cause_e          cause;
    logic [XLEN-1:0] vec_ofs;
    logic [XLEN-1:0] sr_entry;
    logic [XLEN-1:0] tgt_pc_q, tgt_sr_q, tgt_sp_q;
    logic [XLEN-1:0] save_pc_q, save_sr_q;
    logic [XLEN-1:0] rar_q, rsr_q;

    exc_cause_arb #(
        .XLEN      (XLEN),
        .OFS_IADDR (OFS_IADDR),
        .OFS_IMISS (OFS_IMISS),
        .OFS_IPROT (OFS_IPROT),
        .OFS_BKPT  (OFS_BKPT)
    ) u_arb (
        .bkpt      (bkpt_i),
        .iaddr_err (iaddr_err_i),
        .imiss     (imiss_i),
        .iprot     (iprot_i),
        .prot_en   (prot_en_i),
        .dbg_mode  (cur_sr_i[SR_DM_BIT]),
        .cause     (cause),
        .offset    (vec_ofs)
    );

    exc_sr_next #(
        .XLEN (XLEN)
    ) u_srn (
        .sr_in    (cur_sr_i),
        .to_debug (cause == CA_BKPT),
        .sr_out   (sr_entry)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cause == CA_BKPT || (cause == CA_NONE && retd_i))
                    state_d = ST_COMMIT;
                else if (cause != CA_NONE)
                    state_d = ST_PUSH_PC;
            end
            ST_PUSH_PC: state_d = ST_PUSH_SR;
            ST_PUSH_SR: state_d = ST_COMMIT;
            ST_COMMIT:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // captured frame and debug shadow registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_pc_q  <= '0;
            tgt_sr_q  <= '0;
            tgt_sp_q  <= '0;
            save_pc_q <= '0;
            save_sr_q <= '0;
            rar_q     <= '0;
            rsr_q     <= '0;
        end else if (state_q == ST_IDLE) begin
            if (cause != CA_NONE) begin
                tgt_pc_q  <= vec_base_i | vec_ofs;
                tgt_sr_q  <= sr_entry;
                save_pc_q <= cur_pc_i;
                save_sr_q <= cur_sr_i;
                if (cause == CA_BKPT) begin
                    rar_q    <= cur_pc_i;
                    rsr_q    <= cur_sr_i;
                    tgt_sp_q <= cur_sp_i;
                end else begin
                    tgt_sp_q <= cur_sp_i - FRAME_SIZE;
                end
            end else if (retd_i) begin
                tgt_pc_q <= rar_q;
                tgt_sr_q <= rsr_q;
                tgt_sp_q <= cur_sp_i;
            end
        end
    end

    // outputs
    always_comb begin
        busy_o     = 1'b0;
        stk_we_o   = 1'b0;
        stk_addr_o = '0;
        stk_data_o = '0;
        pc_vld_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PUSH_PC: begin
                busy_o     = 1'b1;
                stk_we_o   = 1'b1;
                stk_addr_o = tgt_sp_q + WORD_STEP;
                stk_data_o = save_pc_q;
            end
            ST_PUSH_SR: begin
                busy_o     = 1'b1;
                stk_we_o   = 1'b1;
                stk_addr_o = tgt_sp_q;
                stk_data_o = save_sr_q;
            end
            ST_COMMIT: pc_vld_o = 1'b1;
            default: ;
        endcase
        new_pc_o  = tgt_pc_q;
        new_sr_o  = tgt_sr_q;
        new_sp_o  = tgt_sp_q;
        dbg_rar_o = rar_q;
        dbg_rsr_o = rsr_q;
    end

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
    import exc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int WORD_BYTES = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bkpt_i,
    input logic [XLEN-1:0] cur_pc_i,
    input logic [XLEN-1:0] cur_sr_i,
    input logic            busy_o,
    input logic            stk_we_o,
    input logic [XLEN-1:0] stk_addr_o,
    input logic            pc_vld_o,
    input logic [XLEN-1:0] new_sr_o,
    input logic [XLEN-1:0] new_sp_o,
    input logic [XLEN-1:0] dbg_rar_o
);

    AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        stk_we_o |-> busy_o); // R7

    AST_SECOND_PUSH_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we_o && !$past(stk_we_o)) |=> (stk_we_o && stk_addr_o == $past(stk_addr_o) - XLEN'(WORD_BYTES))); // R5

    AST_COMMIT_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we_o && $past(stk_we_o)) |=> (pc_vld_o && new_sp_o == $past(stk_addr_o))); // R6

    AST_COMMIT_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we_o && $past(stk_we_o)) |=> (new_sr_o[SR_MODE_LSB +: SR_MODE_W] == MODE_EXC && new_sr_o[SR_EM_BIT] && new_sr_o[SR_GM_BIT])); // R3

    AST_BUSY_UNTIL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || pc_vld_o)); // R7

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_vld_o |=> !pc_vld_o); // R7

    AST_BKPT_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bkpt_i && !cur_sr_i[SR_DM_BIT] && !busy_o && !pc_vld_o) |=> (pc_vld_o && !stk_we_o && new_sr_o[SR_DM_BIT] && dbg_rar_o == $past(cur_pc_i))); // R9

endmodule

bind exc_entry_seq exc_entry_seq_chk #(
    .XLEN       (XLEN),
    .WORD_BYTES (WORD_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bkpt_i     (bkpt_i),
    .cur_pc_i   (cur_pc_i),
    .cur_sr_i   (cur_sr_i),
    .busy_o     (busy_o),
    .stk_we_o   (stk_we_o),
    .stk_addr_o (stk_addr_o),
    .pc_vld_o   (pc_vld_o),
    .new_sr_o   (new_sr_o),
    .new_sp_o   (new_sp_o),
    .dbg_rar_o  (dbg_rar_o)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bkpt_i = 1'b0, iaddr_err_i = 1'b0, imiss_i = 1'b0, iprot_i = 1'b0;
    logic        prot_en_i = 1'b0, retd_i = 1'b0;
    logic [31:0] cur_pc_i = '0, cur_sr_i = '0, cur_sp_i = '0, vec_base_i = '0;
    logic        busy_o, stk_we_o, pc_vld_o;
    logic [31:0] stk_addr_o, stk_data_o, new_pc_o, new_sr_o, new_sp_o, dbg_rar_o, dbg_rsr_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] m_rar = '0, m_rsr = '0;

    always #2 clk = ~clk;

    exc_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .bkpt_i(bkpt_i), .iaddr_err_i(iaddr_err_i), .imiss_i(imiss_i), .iprot_i(iprot_i),
        .prot_en_i(prot_en_i), .retd_i(retd_i),
        .cur_pc_i(cur_pc_i), .cur_sr_i(cur_sr_i), .cur_sp_i(cur_sp_i), .vec_base_i(vec_base_i),
        .busy_o(busy_o), .stk_we_o(stk_we_o), .stk_addr_o(stk_addr_o), .stk_data_o(stk_data_o),
        .pc_vld_o(pc_vld_o), .new_pc_o(new_pc_o), .new_sr_o(new_sr_o), .new_sp_o(new_sp_o),
        .dbg_rar_o(dbg_rar_o), .dbg_rsr_o(dbg_rsr_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // 0 none, 1 breakpoint, 2 misaligned, 3 miss, 4 violation (R1, R4, R8)
    function automatic int exp_kind(input logic bk, ia, mi, pr, en, input logic [31:0] sr);
        if (bk && !sr[27])  return 1;
        if (ia)             return 2;
        if (en && mi)       return 3;
        if (en && pr)       return 4;
        return 0;
    endfunction

    function automatic logic [31:0] exp_vec(input int kind, input logic [31:0] base);
        case (kind)
            1:       return base | 32'h1C;
            2:       return base | 32'h14;
            3:       return base | 32'h50;
            default: return base | 32'h18;
        endcase
    endfunction

    function automatic logic [31:0] exp_sr(input logic [31:0] sr, input logic dbg);
        logic [31:0] r = sr;
        r[24:22] = 3'b110;
        r[21] = 1'b1;
        r[16] = 1'b1;
        if (dbg) begin
            r[26] = 1'b1;
            r[27] = 1'b1;
        end
        return r;
    endfunction

    task automatic run_case(input logic bk, ia, mi, pr, en, rt,
                            input logic [31:0] pc, sr, sp, base);
        int kind = exp_kind(bk, ia, mi, pr, en, sr);
        @(negedge clk);
        bkpt_i = bk; iaddr_err_i = ia; imiss_i = mi; iprot_i = pr;
        prot_en_i = en; retd_i = rt;
        cur_pc_i = pc; cur_sr_i = sr; cur_sp_i = sp; vec_base_i = base;
        @(negedge clk);
        bkpt_i = 1'b0; iaddr_err_i = 1'b0; imiss_i = 1'b0; iprot_i = 1'b0; retd_i = 1'b0;
        case (kind)
            0: begin
                if (rt) begin
                    chk("R10 retd valid", 32'(pc_vld_o), 32'd1);
                    chk("R10 retd pc", new_pc_o, m_rar);
                    chk("R10 retd sr", new_sr_o, m_rsr);
                    chk("R10 retd sp", new_sp_o, sp);
                end else begin
                    chk("R4 R8 nothing taken valid", 32'(pc_vld_o), 32'd0);
                    chk("R4 R8 nothing taken busy", 32'(busy_o), 32'd0);
                end
            end
            1: begin
                m_rar = pc;
                m_rsr = sr;
                chk("R9 bkpt valid", 32'(pc_vld_o), 32'd1);
                chk("R9 bkpt no stack write", 32'(stk_we_o), 32'd0);
                chk("R2 bkpt vector", new_pc_o, exp_vec(1, base));
                chk("R9 bkpt sr", new_sr_o, exp_sr(sr, 1'b1));
                chk("R9 bkpt sp", new_sp_o, sp);
                chk("R9 rar", dbg_rar_o, pc);
                chk("R9 rsr", dbg_rsr_o, sr);
            end
            default: begin
                chk("R5 first write strobe", 32'(stk_we_o), 32'd1);
                chk("R7 busy in first write", 32'(busy_o), 32'd1);
                chk("R5 first write addr", stk_addr_o, sp - 32'd4);
                chk("R5 first write data", stk_data_o, pc);
                // spurious causes while busy (R11)
                bkpt_i = 1'b1; iaddr_err_i = 1'b1; retd_i = 1'b1;
                @(negedge clk);
                chk("R5 second write strobe", 32'(stk_we_o), 32'd1);
                chk("R7 busy in second write", 32'(busy_o), 32'd1);
                chk("R5 second write addr", stk_addr_o, sp - 32'd8);
                chk("R5 second write data", stk_data_o, sr);
                @(negedge clk);
                bkpt_i = 1'b0; iaddr_err_i = 1'b0; retd_i = 1'b0;
                chk("R6 commit valid", 32'(pc_vld_o), 32'd1);
                chk("R7 busy low at commit", 32'(busy_o), 32'd0);
                chk("R2 R1 vector", new_pc_o, exp_vec(kind, base));
                chk("R3 entry sr", new_sr_o, exp_sr(sr, 1'b0));
                chk("R6 commit sp", new_sp_o, sp - 32'd8);
                @(negedge clk);
                chk("R11 no re-entry valid", 32'(pc_vld_o), 32'd0);
                chk("R11 no re-entry busy", 32'(busy_o), 32'd0);
                chk("R11 shadow rar untouched", dbg_rar_o, m_rar);
            end
        endcase
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset busy", 32'(busy_o), 32'd0);
        chk("R12 reset valid", 32'(pc_vld_o), 32'd0);
        chk("R12 reset stk_we", 32'(stk_we_o), 32'd0);
        chk("R12 reset rar", dbg_rar_o, 32'd0);
        chk("R12 reset rsr", dbg_rsr_o, 32'd0);
        rst_n = 1'b1;
        void'($urandom(32'd4711));

        // R1: all causes at once -> breakpoint
        run_case(1, 1, 1, 1, 1, 0, 32'h0000_1000, 32'h0000_0000, 32'h2000_0100, 32'h8000_0000);
        // R10: retd restores shadow
        run_case(0, 0, 0, 0, 0, 1, 32'h0, 32'h0800_0000, 32'h2000_0200, 32'h0);
        // R1: misaligned beats protection causes
        run_case(0, 1, 1, 1, 1, 0, 32'h0000_2002, 32'h0000_0003, 32'h2000_0300, 32'h8000_0000);
        // R1: miss beats violation
        run_case(0, 0, 1, 1, 1, 0, 32'h0000_3000, 32'h00C0_0000, 32'h2000_0400, 32'h8000_0100);
        // R2: violation alone
        run_case(0, 0, 0, 1, 1, 0, 32'h0000_4000, 32'hFFFF_FFFF & ~32'h0800_0000, 32'h2000_0500, 32'h8000_0200);
        // R4: protection causes with unit disabled
        run_case(0, 0, 1, 1, 0, 0, 32'h0000_5000, 32'h0, 32'h2000_0600, 32'h8000_0000);
        // R8: breakpoint in debug mode falls to violation
        run_case(1, 0, 0, 1, 1, 0, 32'h0000_6000, 32'h0800_0000, 32'h2000_0700, 32'h8000_0000);
        // R8: breakpoint in debug mode alone ignored
        run_case(1, 0, 0, 0, 0, 0, 32'h0000_7000, 32'h0800_0000, 32'h2000_0800, 32'h8000_0000);
        // R10: exception wins over retd
        run_case(0, 1, 0, 0, 0, 1, 32'h0000_8001, 32'h0, 32'h2000_0900, 32'h8000_0000);
        // R10: shadow still holds earlier breakpoint state
        run_case(0, 0, 0, 0, 0, 1, 32'h0, 32'h0, 32'h2000_0A00, 32'h0);

        for (int i = 0; i < 400; i++) begin
            run_case(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     1'($urandom), 1'($urandom),
                     $urandom, $urandom, $urandom, $urandom);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule